// File: doc/BRIEF.md
# Order-Wire Serial Byte Capture

This block takes the serial order-wire stream that a section-overhead port emits and rebuilds the three order-wire bytes of each frame: E1, then F1, then E2. The sender changes the data bit, the valid qualifier and the frame-start pulse on the falling edge of the overhead clock. The block samples all three on the rising edge.

A frame starts only on an edge where the start pulse and valid are both high. The bit sampled on that edge is the first order-wire bit. Each later edge with valid high shifts in one more bit, and the first edge with valid low ends the capture. A complete record is exactly 24 bits. When it closes, the three byte outputs update together and a one-cycle ready strobe is raised. A short record, an over-long record or a restart in mid-record leaves the outputs unchanged and sets a sticky error flag.

Top module: `ow_byte_capture`

## Requirements
- R1: A synchronous active-low reset clears the three byte outputs to 0x00 and the ready strobe and error flag to 0, visible after the first rising edge that samples reset low.
- R2: While no capture is in progress, an edge with valid high but no start pulse, or with the start pulse high but valid low, starts nothing and changes no output.
- R3: Bits are packed MSB first. The first captured bit lands in bit 7 of E1. Bits 0 to 7 of the record fill E1, bits 8 to 15 fill F1, and bits 16 to 23 fill E2.
- R4: When 24 bits have been captured and the next edge samples valid low, all three bytes update and the ready strobe is high for exactly one cycle, starting after that edge.
- R5: If valid is sampled low after fewer than 24 bits, the error flag is set, no ready strobe is raised and the byte outputs keep their previous values.
- R6: If valid is still high on the edge after the 24th bit, the record is dropped, the error flag is set and no ready strobe is raised.
- R7: A start pulse sampled with valid during a capture discards the partial record and sets the error flag. That edge's bit is taken as the first bit of a new record, which then completes normally.
- R8: Once set, the error flag stays high until reset, including across later good records.
- R9: The byte outputs change only in a cycle where the ready strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Overhead clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ow_bit | input | 1 | Serial order-wire data bit |
| ow_vld | input | 1 | Data-valid qualifier |
| ow_sof | input | 1 | Frame-start pulse, aligned with the first E1 bit |
| e1_byte | output | BYTE_W | Last completed E1 byte |
| f1_byte | output | BYTE_W | Last completed F1 byte |
| e2_byte | output | BYTE_W | Last completed E2 byte |
| bytes_rdy | output | 1 | One-cycle strobe marking fresh bytes |
| ow_err | output | 1 | Sticky framing error flag |

## Verification
The ready strobe and the new bytes appear in the cycle after the rising edge that samples valid low on a full record; that is one register past the sampling edge. The error flag also rises one cycle after the edge that sampled the offending condition. The bench drives inputs on the falling edge and updates its reference model on the rising edge. It compares every output at the next falling edge, so each expectation is read in exactly the cycle it becomes due.

// File: rtl/ow_cap_pkg.sv
// Shared types for the order-wire capture block.
package ow_cap_pkg;
    // Capture controller state: waiting for a start, or inside a record.
    typedef enum logic {
        OW_IDLE = 1'b0,
        OW_CAPT = 1'b1
    } ow_state_e;
endpackage

// File: rtl/ow_frame_ctrl.sv
// Capture controller. Decides on each sampled edge whether to start a record,
// shift a bit, close a complete record or flag an error, and holds the
// sticky error flag. Assumes cnt_full is the shifter's "record holds all bits".
module ow_frame_ctrl
    import ow_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic sof,
    input  logic cnt_full,
    output logic load_first,
    output logic shift_en,
    output logic commit,
    output logic err_q
);
    ow_state_e state_q, state_d;
    logic      start;
    logic      in_rec;
    logic      err_evt;

    // Decode the action for this edge from state and sampled inputs.
    always_comb begin
        start      = sof & vld;
        in_rec     = (state_q == OW_CAPT);
        load_first = start;
        shift_en   = in_rec & vld & ~sof & ~cnt_full;
        commit     = in_rec & ~vld & cnt_full;
        err_evt    = in_rec & (start | (vld & cnt_full) | (~vld & ~cnt_full));
        state_d    = state_q;
        if (start)
            state_d = OW_CAPT;
        else if (in_rec && (!vld || cnt_full))
            state_d = OW_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OW_IDLE;
        else        state_q <= state_d;
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_evt) err_q <= 1'b1;
    end
endmodule

// File: rtl/ow_bit_shifter.sv
// Serial-to-parallel shifter with bit counter. A load restarts the record with
// the current bit; a shift appends MSB first. Assumes load and shift are never
// requested on the same edge with conflicting intent (load wins).
module ow_bit_shifter #(
    parameter int TOTAL_BITS = 24,
    localparam int CNT_W     = $clog2(TOTAL_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  din,
    input  logic                  load_first,
    input  logic                  shift_en,
    output logic [TOTAL_BITS-1:0] rec_q,
    output logic                  cnt_full
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TOTAL_BITS);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Shift register and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
            cnt_q <= '0;
        end else if (load_first) begin
            rec_q <= {{(TOTAL_BITS-1){1'b0}}, din};
            cnt_q <= ONE_CNT;
        end else if (shift_en) begin
            rec_q <= {rec_q[TOTAL_BITS-2:0], din};
            cnt_q <= cnt_q + ONE_CNT;
        end
    end

    // Full-record indication.
    always_comb cnt_full = (cnt_q == FULL_CNT);
endmodule

// File: rtl/ow_out_regs.sv
// Output byte registers and ready strobe. On commit, every byte lane loads its
// slice of the record together. Lane 0 takes the earliest bits.
module ow_out_regs #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int REC_W    = BYTE_W * NUM_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [REC_W-1:0] rec,
    output logic [REC_W-1:0] lanes_q,
    output logic             rdy_q
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_BYTES; gi++) begin : g_lane
            // Byte lane gi: loads from the record on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lanes_q[gi*BYTE_W +: BYTE_W] <= '0;
                else if (commit)
                    lanes_q[gi*BYTE_W +: BYTE_W] <= rec[REC_W-1-gi*BYTE_W -: BYTE_W];
            end
        end
    endgenerate

    // One-cycle ready strobe following a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= commit;
    end
endmodule

// File: rtl/ow_byte_capture.sv
// Top level: rebuilds the E1, F1 and E2 order-wire bytes from a serial stream
// sampled on the rising overhead clock. Assumes the sender changes its
// outputs on the falling edge, so all inputs are stable at the rising edge.
module ow_byte_capture #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ow_bit,
    input  logic              ow_vld,
    input  logic              ow_sof,
    output logic [BYTE_W-1:0] e1_byte,
    output logic [BYTE_W-1:0] f1_byte,
    output logic [BYTE_W-1:0] e2_byte,
    output logic              bytes_rdy,
    output logic              ow_err
);
    localparam int NUM_BYTES = 3;
    localparam int REC_W     = BYTE_W * NUM_BYTES;

    logic             load_first;
    logic             shift_en;
    logic             commit;
    logic             cnt_full;
    logic [REC_W-1:0] rec;
    logic [REC_W-1:0] lanes;

    ow_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld        (ow_vld),
        .sof        (ow_sof),
        .cnt_full   (cnt_full),
        .load_first (load_first),
        .shift_en   (shift_en),
        .commit     (commit),
        .err_q      (ow_err)
    );

    ow_bit_shifter #(.TOTAL_BITS(REC_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (ow_bit),
        .load_first (load_first),
        .shift_en   (shift_en),
        .rec_q      (rec),
        .cnt_full   (cnt_full)
    );

    ow_out_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .rec     (rec),
        .lanes_q (lanes),
        .rdy_q   (bytes_rdy)
    );

    // Lane 0 holds the earliest byte (E1).
    always_comb begin
        e1_byte = lanes[0*BYTE_W +: BYTE_W];
        f1_byte = lanes[1*BYTE_W +: BYTE_W];
        e2_byte = lanes[2*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ow_byte_capture_chk.sv
// Property checker for ow_byte_capture, attached through bind.
module ow_byte_capture_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ow_vld,
    input logic [BYTE_W-1:0] e1_byte,
    input logic [BYTE_W-1:0] f1_byte,
    input logic [BYTE_W-1:0] e2_byte,
    input logic              bytes_rdy,
    input logic              ow_err
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!bytes_rdy && !ow_err && e1_byte == '0 && f1_byte == '0 && e2_byte == '0));

    // R4
    rdy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_rdy |=> !bytes_rdy);

    // R4
    rdy_after_vld_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_rdy |-> !$past(ow_vld));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ow_err |=> ow_err);

    // R9
    bytes_change_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(e1_byte) && $stable(f1_byte) && $stable(e2_byte)) |-> bytes_rdy);
endmodule

bind ow_byte_capture ow_byte_capture_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ow_vld    (ow_vld),
    .e1_byte   (e1_byte),
    .f1_byte   (f1_byte),
    .e2_byte   (e2_byte),
    .bytes_rdy (bytes_rdy),
    .ow_err    (ow_err)
);

// File: tb/ow_byte_capture_tb_top.sv
module ow_byte_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ow_bit = 1'b0;
    logic       ow_vld = 1'b0;
    logic       ow_sof = 1'b0;
    logic [7:0] e1_byte, f1_byte, e2_byte;
    logic       bytes_rdy, ow_err;

    int checks = 0;
    int errors = 0;
    int rdy_cnt = 0;
    bit done = 1'b0;
    bit model_live = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    bit       q[$];
    bit       m_active = 1'b0;
    bit       m_rdy = 1'b0;
    bit       m_err = 1'b0;
    bit [7:0] m_e1 = 8'h00, m_f1 = 8'h00, m_e2 = 8'h00;

    always #2.5 clk = ~clk;

    ow_byte_capture #(.BYTE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ow_bit(ow_bit), .ow_vld(ow_vld), .ow_sof(ow_sof),
        .e1_byte(e1_byte), .f1_byte(f1_byte), .e2_byte(e2_byte),
        .bytes_rdy(bytes_rdy), .ow_err(ow_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: bits kept in a queue, evaluated on each rising edge.
    always @(posedge clk) begin
        bit [23:0] word;
        model_live = 1'b1;
        m_rdy = 1'b0;
        if (!rst_n) begin
            q.delete(); m_active = 0; m_err = 0;
            m_e1 = 0; m_f1 = 0; m_e2 = 0;
        end else if (ow_sof && ow_vld) begin
            if (m_active) m_err = 1;
            q.delete(); q.push_back(ow_bit); m_active = 1;
        end else if (m_active) begin
            if (ow_vld) begin
                if (q.size() == 24) begin m_err = 1; m_active = 0; end
                else q.push_back(ow_bit);
            end else begin
                if (q.size() == 24) begin
                    word = '0;
                    foreach (q[i]) word = {word[22:0], q[i]};
                    m_e1 = word[23:16]; m_f1 = word[15:8]; m_e2 = word[7:0];
                    m_rdy = 1;
                end else m_err = 1;
                m_active = 0;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (model_live && !done) begin
            chk(cur_req, "e1", e1_byte, m_e1);
            chk(cur_req, "f1", f1_byte, m_f1);
            chk(cur_req, "e2", e2_byte, m_e2);
            chk(cur_req, "rdy", bytes_rdy, m_rdy);
            chk(cur_req, "err", ow_err, m_err);
            if (bytes_rdy === 1'b1) rdy_cnt++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ow_sof = 0; ow_vld = 0; ow_bit = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        idle(3);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic send(input logic [23:0] d, input int nbits, input int gap);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ow_sof = (i == 0); ow_vld = 1;
            ow_bit = (i < 24) ? d[23-i] : 1'b1;
        end
        idle(gap);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int r0;
        // R1: reset state
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R1", "err after reset", ow_err, 0);
        chk("R1", "e1 after reset", e1_byte, 8'h00);

        // R2: stray valid and stray start while idle
        cur_req = "R2";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); ow_vld = 1; ow_sof = 0; ow_bit = i[0];
        end
        @(negedge clk); ow_vld = 0; ow_sof = 1; ow_bit = 1;
        idle(3);
        chk("R2", "no rdy from stray inputs", rdy_cnt, 0);
        chk("R2", "no err from stray inputs", ow_err, 0);

        // R3 R4: good records, MSB-first packing
        cur_req = "R3";
        r0 = rdy_cnt;
        send(24'hA53CF0, 24, 3);
        chk("R3", "E1", e1_byte, 8'hA5);
        chk("R3", "F1", f1_byte, 8'h3C);
        chk("R3", "E2", e2_byte, 8'hF0);
        chk("R4", "one rdy pulse", rdy_cnt - r0, 1);
        cur_req = "R4";
        send(24'h0180FF, 24, 1);
        send(24'h7E8142, 24, 3);
        chk("R4", "back-to-back E1", e1_byte, 8'h7E);
        chk("R4", "back-to-back E2", e2_byte, 8'h42);
        chk("R4", "two more rdy pulses", rdy_cnt - r0, 3);

        // R5: short record
        cur_req = "R5";
        r0 = rdy_cnt;
        send(24'h123456, 10, 3);
        chk("R5", "err set", ow_err, 1);
        chk("R5", "E1 kept", e1_byte, 8'h7E);
        chk("R5", "no rdy", rdy_cnt - r0, 0);

        // R1 clears err; R6: long record
        cur_req = "R1";
        do_reset();
        #1;
        chk("R1", "err cleared", ow_err, 0);
        cur_req = "R6";
        r0 = rdy_cnt;
        send(24'hDEADBE, 25, 3);
        chk("R6", "err set", ow_err, 1);
        chk("R6", "no rdy", rdy_cnt - r0, 0);
        chk("R6", "E1 unchanged", e1_byte, 8'h00);

        // R7: restart in mid-record; R8: err stays across good record
        do_reset();
        cur_req = "R7";
        r0 = rdy_cnt;
        send(24'hFFFFFF, 12, 0);
        send(24'hC3965A, 24, 3);
        chk("R7", "new record E1", e1_byte, 8'hC3);
        chk("R7", "new record F1", f1_byte, 8'h96);
        chk("R7", "new record E2", e2_byte, 8'h5A);
        chk("R7", "err set", ow_err, 1);
        chk("R7", "one rdy", rdy_cnt - r0, 1);
        cur_req = "R8";
        send(24'h111111, 24, 3);
        chk("R8", "err still set", ow_err, 1);
        chk("R9", "bytes updated once", e1_byte, 8'h11);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule